// File: doc/BRIEF.md
# Programmable SPI Master Clock Generator

This block derives the serial clock of an SPI master from the system clock. A pre-divider issues a one-cycle enable every PRE+1 system cycles, and a main counter that advances only on that enable runs from 0 to N and wraps. The serial clock is a register. It is set when the main counter reaches the high compare point H and cleared when it reaches the low compare point L. The pair (H, L) therefore fixes the duty cycle, and N fixes the period. A bypass setting sends the system clock straight to the output instead.

The divider fields are captured into shadow registers only while the configuration strobe is high. Changes to the field inputs at any other time have no effect, so a transfer always runs with stable settings. While the configuration strobe is high the counters are held at zero and the divided clock is low. In slave mode the generator drives no clock. Every change of the divided clock comes with a one-cycle rising or falling strobe in the same cycle. The SPI shift logic uses these strobes to launch and capture data.

Top module: `sclk_gen`

## Requirements
- R1: While `rstN` is low, `sclkOut`, `riseStb` and `fallStb` are all 0.
- R2: With bypass off, master mode and N >= 1, the divided clock has a period of (PRE+1)*(N+1) system cycles.
- R3: On each enable, a main count equal to L clears the clock and a count equal to H sets it. L wins if both match. With H < L <= N the clock is high for (L-H)*(PRE+1) system cycles per period.
- R4: With N = 0 and bypass off, the clock toggles on every pre-divider enable, giving a period of 2*(PRE+1) cycles and a high time of PRE+1 cycles.
- R5: With the bypass bit captured as 1, master mode and the configuration strobe low, `sclkOut` equals the system clock, and `riseStb` and `fallStb` are both held at 1. Bypass takes effect from the second system cycle after these conditions first hold.
- R6: In slave mode (`isMaster` = 0) `sclkOut` is 0 and no rising strobe occurs. After one cycle of settling, no falling strobe occurs either.
- R7: PRE, N, H, L and BYPASS are captured only in cycles where `cfgActive` is 1. Changes at other times do not alter the clock. While `cfgActive` is 1 the counters are held at zero and the divided clock stays low.
- R8: In divided mode, `riseStb` is 1 in exactly the cycle in which `sclkOut` first reads 1, and `fallStb` is 1 in exactly the cycle in which it first reads 0. The two strobes are never 1 together.
- R9: After reset the captured settings are PRE=0, N=3, H=1, L=3 and BYPASS=1, so a master leaves reset in bypass mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| isMaster | input | 1 | 1 = master mode, 0 = slave mode (no clock driven) |
| cfgActive | input | 1 | Configuration state; fields are captured while high |
| cfgPre | input | 13 | Pre-divider value PRE |
| cfgN | input | 6 | Main divider terminal count N |
| cfgH | input | 6 | Main count at which the clock goes high |
| cfgL | input | 6 | Main count at which the clock goes low |
| cfgBypass | input | 1 | 1 = serial clock equals system clock |
| sclkOut | output | 1 | Serial clock |
| riseStb | output | 1 | One-cycle strobe in the cycle the clock rises |
| fallStb | output | 1 | One-cycle strobe in the cycle the clock falls |

## Verification
The hardest behaviour to reach is a change to the field inputs that arrives outside the configuration state while a divided clock is already running, because the design must ignore it. The bench reaches it by starting a slow clock, changing every field to a very different value with the strobe low, and measuring period and high time again. The N = 0 toggle path and compare points away from the default half-duty values are each reached through a dedicated configuration, with the period and high time measured over a full settled cycle.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;
  parameter int PRE_W = 13;
  parameter int CNT_W = 6;

  // Strobes from the control unit to the output datapath
  typedef struct packed {
    logic clear;   // force divided clock low (not running)
    logic toggle;  // N == 0: invert on this enable
    logic hitHigh; // count equals high compare point on this enable
    logic hitLow;  // count equals low compare point on this enable
  } clk_stb_t;
endpackage

// File: rtl/sclk_gen_ctrl.sv
module sclk_gen_ctrl
  import sclk_gen_pkg::*;
#(
  parameter int PW = PRE_W,
  parameter int CW = CNT_W,
  parameter logic [PW-1:0] RST_PRE = '0,
  parameter logic [CW-1:0] RST_N   = CW'(3),
  parameter logic [CW-1:0] RST_H   = CW'(1),
  parameter logic [CW-1:0] RST_L   = CW'(3),
  parameter logic          RST_BYP = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          isMaster,
  input  logic          cfgActive,
  input  logic [PW-1:0] cfgPre,
  input  logic [CW-1:0] cfgN,
  input  logic [CW-1:0] cfgH,
  input  logic [CW-1:0] cfgL,
  input  logic          cfgBypass,
  output clk_stb_t      stb,
  output logic          bypassAct
);
  logic [PW-1:0] shPre;
  logic [CW-1:0] shN, shH, shL;
  logic          shByp;
  logic [PW-1:0] preCnt;
  logic [CW-1:0] mainCnt;
  logic          run;
  logic          tick;

  // Shadow capture only in configuration state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shPre <= RST_PRE;
      shN   <= RST_N;
      shH   <= RST_H;
      shL   <= RST_L;
      shByp <= RST_BYP;
    end else if (cfgActive) begin
      shPre <= cfgPre;
      shN   <= cfgN;
      shH   <= cfgH;
      shL   <= cfgL;
      shByp <= cfgBypass;
    end
  end

  assign run  = !cfgActive && isMaster && !shByp;
  assign tick = run && (preCnt == shPre);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt    <= '0;
      mainCnt   <= '0;
      bypassAct <= 1'b0;
    end else begin
      bypassAct <= isMaster && shByp && !cfgActive;
      if (!run) begin
        preCnt  <= '0;
        mainCnt <= '0;
      end else begin
        preCnt <= tick ? '0 : preCnt + 1'b1;
        if (tick) mainCnt <= (mainCnt == shN) ? '0 : mainCnt + 1'b1;
      end
    end
  end

  always_comb begin
    stb.clear   = !run;
    stb.toggle  = tick && (shN == '0);
    stb.hitHigh = tick && (mainCnt == shH);
    stb.hitLow  = tick && (mainCnt == shL);
  end

  // R2: main count never passes the captured terminal count
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    mainCnt <= shN);
  // R2: pre-divider never passes its captured limit
  p_pre_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= shPre);
  // R7: configuration state parks both counters
  p_cfg_park_r7: assert property (@(posedge clk) disable iff (!rstN)
    cfgActive |=> (preCnt == '0) && (mainCnt == '0));
endmodule

// File: rtl/sclk_gen_dp.sv
module sclk_gen_dp
  import sclk_gen_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  clk_stb_t stb,
  output logic     sclkReg,
  output logic     riseReg,
  output logic     fallReg
);
  logic nxt;

  always_comb begin
    if (stb.clear)        nxt = 1'b0;
    else if (stb.toggle)  nxt = ~sclkReg;
    else if (stb.hitLow)  nxt = 1'b0;
    else if (stb.hitHigh) nxt = 1'b1;
    else                  nxt = sclkReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkReg <= 1'b0;
      riseReg <= 1'b0;
      fallReg <= 1'b0;
    end else begin
      sclkReg <= nxt;
      riseReg <= nxt & ~sclkReg;
      fallReg <= ~nxt & sclkReg;
    end
  end

  // R8: strobes are exclusive
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(riseReg && fallReg));
  // R8: rising strobe marks a real 0->1 change of the registered clock
  p_rise_edge_r8: assert property (@(posedge clk) disable iff (!rstN)
    riseReg |-> (sclkReg && !$past(sclkReg)));
  // R8: falling strobe marks a real 1->0 change
  p_fall_edge_r8: assert property (@(posedge clk) disable iff (!rstN)
    fallReg |-> (!sclkReg && $past(sclkReg)));
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
  import sclk_gen_pkg::*;
#(
  parameter int PW = PRE_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          isMaster,
  input  logic          cfgActive,
  input  logic [PW-1:0] cfgPre,
  input  logic [CW-1:0] cfgN,
  input  logic [CW-1:0] cfgH,
  input  logic [CW-1:0] cfgL,
  input  logic          cfgBypass,
  output logic          sclkOut,
  output logic          riseStb,
  output logic          fallStb
);
  clk_stb_t stb;
  logic     bypassAct;
  logic     sclkReg, riseReg, fallReg;

  sclk_gen_ctrl #(.PW(PW), .CW(CW)) ctrl_i (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .cfgActive(cfgActive),
    .cfgPre(cfgPre), .cfgN(cfgN), .cfgH(cfgH), .cfgL(cfgL),
    .cfgBypass(cfgBypass), .stb(stb), .bypassAct(bypassAct)
  );

  sclk_gen_dp dp_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .sclkReg(sclkReg), .riseReg(riseReg), .fallReg(fallReg)
  );

  assign sclkOut = bypassAct ? clk  : sclkReg;
  assign riseStb = bypassAct | riseReg;
  assign fallStb = bypassAct | fallReg;

  // R6: slave mode leaves the clock low with no rising strobe next cycle
  p_slave_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !isMaster |=> (!sclkOut && !riseStb));
  // R7: configuration state keeps the divided clock low
  p_cfg_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    cfgActive |=> !sclkReg);
endmodule

// File: tb/sclk_gen_tb_top.sv
`timescale 1ns/1ps
module sclk_gen_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        isMaster;
  logic        cfgActive;
  logic [12:0] cfgPre;
  logic [5:0]  cfgN, cfgH, cfgL;
  logic        cfgBypass;
  logic        sclkOut, riseStb, fallStb;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk; // 250 MHz

  sclk_gen dut_i (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .cfgActive(cfgActive),
    .cfgPre(cfgPre), .cfgN(cfgN), .cfgH(cfgH), .cfgL(cfgL),
    .cfgBypass(cfgBypass), .sclkOut(sclkOut), .riseStb(riseStb),
    .fallStb(fallStb)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic configure(input int pre, input int n, input int h, input int l,
                           input bit byp);
    @(negedge clk);
    cfgPre = 13'(pre); cfgN = 6'(n); cfgH = 6'(h); cfgL = 6'(l);
    cfgBypass = byp; cfgActive = 1'b1;
    @(negedge clk);
    check(sclkOut == 1'b0, "R7 low in config", int'(sclkOut), 0);
    @(negedge clk);
    cfgActive = 1'b0;
  endtask

  // Measure one settled period: rises r1,r2 and fall f between them
  task automatic measure(input int expPer, input int expHigh, input string tag);
    int idx = 0, nRise = 0, r1 = 0, r2 = 0, f = -1, highCnt = 0;
    bit both = 0;
    while (nRise < 3 && idx < 4000) begin
      @(negedge clk);
      idx++;
      if (riseStb && fallStb) both = 1;
      if (nRise == 2 && sclkOut) highCnt++;
      if (nRise == 2 && fallStb && f < 0) f = idx;
      if (riseStb) begin
        nRise++;
        if (nRise == 2) begin r1 = idx; highCnt = 1; end
        if (nRise == 3) begin r2 = idx; highCnt--; end
        check(sclkOut == 1'b1, {tag, " R8 rise strobe with high clock"}, int'(sclkOut), 1);
      end
      if (fallStb) check(sclkOut == 1'b0, {tag, " R8 fall strobe with low clock"}, int'(sclkOut), 0);
    end
    check(nRise == 3, {tag, " edges seen"}, nRise, 3);
    check(r2 - r1 == expPer, {tag, " R2 period"}, r2 - r1, expPer);
    check(f - r1 == expHigh, {tag, " R3 high time"}, f - r1, expHigh);
    check(highCnt == expHigh, {tag, " R3 high samples"}, highCnt, expHigh);
    check(!both, {tag, " R8 strobes exclusive"}, int'(both), 0);
  endtask

  task automatic t_reset();
    rstN = 1'b0; isMaster = 1'b1; cfgActive = 1'b0; cfgPre = '0;
    cfgN = '0; cfgH = '0; cfgL = '0; cfgBypass = 1'b0;
    repeat (3) @(negedge clk);
    check(!sclkOut && !riseStb && !fallStb, "R1 reset outputs", int'({sclkOut, riseStb, fallStb}), 0);
    @(posedge clk); #1;
    check(sclkOut == 1'b0, "R1 reset clock high phase", int'(sclkOut), 0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic t_default_bypass();
    repeat (3) @(negedge clk);
    @(posedge clk); #1;
    check(sclkOut == 1'b1, "R9 R5 default bypass high phase", int'(sclkOut), 1);
    check(riseStb && fallStb, "R5 bypass strobes", int'({riseStb, fallStb}), 3);
    @(negedge clk); #1;
    check(sclkOut == 1'b0, "R9 R5 default bypass low phase", int'(sclkOut), 0);
  endtask

  task automatic t_divided();
    configure(0, 3, 1, 3, 0); measure(4, 2, "R2 p0n3");
    configure(2, 3, 1, 3, 0); measure(12, 6, "R2 p2n3");
    configure(1, 4, 1, 4, 0); measure(10, 6, "R3 p1n4");
    configure(4, 7, 3, 7, 0); measure(40, 20, "R2 p4n7");
    configure(0, 5, 0, 3, 0); measure(6, 3, "R3 custom h0l3");
    configure(0, 5, 3, 3, 0); // R3: L wins when H == L, so no clock
    repeat (30) begin
      @(negedge clk);
      check(!sclkOut && !riseStb, "R3 low compare priority", int'(sclkOut), 0);
    end
  endtask

  task automatic t_n_zero();
    configure(3, 0, 0, 0, 0); measure(8, 4, "R4 p3n0");
    configure(0, 0, 0, 0, 0); measure(2, 1, "R4 p0n0");
  endtask

  task automatic t_shadow_hold();
    configure(2, 3, 1, 3, 0);
    repeat (5) @(negedge clk);
    cfgPre = 13'd0; cfgN = 6'd0; cfgH = 6'd0; cfgL = 6'd0; cfgBypass = 1'b1;
    measure(12, 6, "R7 fields ignored outside config");
  endtask

  task automatic t_bypass_cfg();
    configure(5, 5, 2, 5, 1);
    repeat (2) @(negedge clk);
    @(posedge clk); #1;
    check(sclkOut == 1'b1, "R5 bypass high phase", int'(sclkOut), 1);
    @(negedge clk); #1;
    check(sclkOut == 1'b0, "R5 bypass low phase", int'(sclkOut), 0);
  endtask

  task automatic t_slave();
    int edges = 0, highs = 0;
    configure(0, 3, 1, 3, 0);
    repeat (10) @(negedge clk);
    isMaster = 1'b0;
    repeat (2) @(negedge clk);
    repeat (100) begin
      @(posedge clk); #1;
      if (sclkOut) highs++;
      @(negedge clk);
      if (sclkOut) highs++;
      if (riseStb || fallStb) edges++;
    end
    check(highs == 0, "R6 slave clock low", highs, 0);
    check(edges == 0, "R6 slave no strobes", edges, 0);
    isMaster = 1'b1;
  endtask

  initial begin
    t_reset();
    t_default_bypass();
    t_divided();
    t_n_zero();
    t_shadow_hold();
    t_bypass_cfg();
    t_slave();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule